// File: doc/BRIEF.md
# Shared-Line UART Engine with Collision Detection

This block sends and receives asynchronous character frames on a single shared wire. Its transmit pin and receive pin are tied to the same open-drain line. While a frame goes out, the receiver path watches the line. At one chosen point inside every driven bit, the level the block is driving is compared with the level it reads back. A mismatch means another node is pulling the line. The block then raises a sticky collision flag and a one-cycle interrupt. It stops driving for the rest of that frame, and it can also drop its own transmit enable so that no further word goes out until software enables it again.

A frame has one start bit, `DATA_BITS` data bits (least significant first, 9 by default), no parity and one stop bit. Each bit lasts 16 baud ticks. In a higher-level protocol, one such frame typically encodes one bit of a slower bus. Transmission can begin as soon as a word is written, or it can wait for a falling edge on the line. One polarity control inverts both pins together. The receiver always runs, so the block also receives every frame it sends.

Top module: `shared_bus_uart`

## Requirements
- R1: The line idles high. A frame is a low start bit, then `DATA_BITS` data bits least significant first, then one high stop bit, each lasting 16 `baud_tick` pulses. The timing holds for any tick spacing.
- R2: With `inv_pol` = 1, the `txd` pin carries the complement of the R1 waveform, and `rxd` is complemented before use.
- R3: With `start_sel` = 0 and transmit enabled, a written word moves to the shift register on the next clock. The start bit begins, `tx_buf_empty` returns to 1, and `irq_tx` pulses for one cycle.
- R4: With `start_sel` = 1, a buffered word stays in the buffer (`tx_reg_empty` = 1, line idle) until the synchronised line shows a falling edge. The frame then starts.
- R5: While start, data or stop bits are driven and `col_det_en` = 1, a difference between the driven level and the synchronised line level sets `col_flag` and pulses `irq_col`. With `col_det_en` = 0, nothing is flagged.
- R6: `samp_late` = 0 compares at tick 8 of a bit. `samp_late` = 1 compares at tick 15. A disturbance that covers only one of these points is detected only under the matching setting.
- R7: After a collision, the line is held at idle until the end of the current frame. `col_flag` stays 1 until a `col_clr` pulse.
- R8: With `auto_clr` = 1, a collision clears `tx_enable`, and a word written afterwards is not sent. With `auto_clr` = 0, `tx_enable` is unchanged.
- R9: A frame received with a valid start bit appears on `rx_data` with `rx_done` = 1 and a one-cycle `irq_rx` pulse. `rx_rd` clears `rx_done`.
- R10: `err_overrun` is set when a frame completes while `rx_done` is still 1, and cleared when a frame completes after a read.
- R11: `err_frame` is set when the stop bit is sampled low. `err_sum` is the OR of `err_overrun` and `err_frame`.
- R12: After reset, `txd` is idle, both transmit-empty flags are 1, and `tx_enable`, `rx_done`, `col_flag` and `err_sum` are 0.
- R13: `tx_reg_empty` is 0 from the start bit until the end of the stop bit, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| txe_wr | input | 1 | Write strobe for the transmit enable |
| txe_val | input | 1 | Value written to the transmit enable |
| rx_en | input | 1 | Receiver enable |
| inv_pol | input | 1 | Inverts both pins |
| col_det_en | input | 1 | Collision comparison enable |
| samp_late | input | 1 | Comparison at tick 15 (1) or tick 8 (0) |
| auto_clr | input | 1 | Collision clears the transmit enable |
| start_sel | input | 1 | 0: start on write, 1: wait for a line falling edge |
| tx_wr | input | 1 | Transmit buffer write strobe |
| tx_data | input | DATA_BITS | Word to transmit |
| rx_rd | input | 1 | Acknowledges the received word |
| col_clr | input | 1 | Clears the collision flag |
| rxd | input | 1 | Line input |
| txd | output | 1 | Line output |
| tx_enable | output | 1 | Current transmit enable |
| tx_buf_empty | output | 1 | Transmit buffer empty |
| tx_reg_empty | output | 1 | No frame in progress |
| irq_tx | output | 1 | Pulse when the buffer moves to the shift register |
| rx_data | output | DATA_BITS | Last received word |
| rx_done | output | 1 | Reception complete |
| err_overrun | output | 1 | Overrun error |
| err_frame | output | 1 | Framing error |
| err_sum | output | 1 | Summary error |
| irq_rx | output | 1 | Pulse on reception complete |
| col_flag | output | 1 | Sticky collision flag |
| irq_col | output | 1 | Pulse on a detected collision |

## Verification
The hardest case to set up is a disturbance that one comparison point sees and the other does not. Producing it means changing the line during only part of a single bit. The bench issues one tick per clock, so every bit boundary is a fixed number of clocks after the write strobe. It then inverts the looped-back line over a window of a few clocks placed either around tick 8 or around tick 15 of a chosen bit, and runs each placement under both `samp_late` settings. Tapping the looped-back line during the stop bit, with the comparison disabled, produces the framing error.

// File: rtl/sbu_pkg.sv
package sbu_pkg;

    localparam int OVS = 16;
    localparam int CW  = $clog2(OVS);

    localparam logic [CW-1:0] SP_MID = CW'(OVS / 2);
    localparam logic [CW-1:0] SP_END = CW'(OVS - 1);
    localparam logic [CW-1:0] RX_MID = CW'(OVS / 2 - 1);

    typedef enum logic [2:0] {
        TX_IDLE, TX_WAIT, TX_START, TX_DATA, TX_STOP
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic overrun;
        logic framing;
    } rx_err_t;

    function automatic logic [CW-1:0] cmp_point(input logic late);
        return late ? SP_END : SP_MID;
    endfunction

endpackage

// File: rtl/sbu_tx.sv
module sbu_tx import sbu_pkg::*; #(
    parameter int DATA_BITS = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 start_sel,
    input  logic                 enable,
    input  logic                 wr,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic                 line_fall,
    input  logic                 col_hit,
    output logic                 line_out,
    output logic                 checking,
    output logic [CW-1:0]        tick_cnt,
    output logic                 buf_empty,
    output logic                 reg_empty,
    output logic                 load_pulse
);
    localparam int IW = $clog2(DATA_BITS + 1);

    tx_state_e            st;
    logic [CW-1:0]        cnt;
    logic [IW-1:0]        idx;
    logic [DATA_BITS-1:0] hold_q;
    logic [DATA_BITS-1:0] shift_q;
    logic                 released;
    logic                 go;
    logic                 bit_end;
    logic                 drive;

    assign bit_end = tick && (cnt == SP_END);

    always_comb begin
        go = 1'b0;
        if (!buf_empty && enable) begin
            if (st == TX_IDLE && !start_sel) go = 1'b1;
            if (st == TX_WAIT && line_fall)  go = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= TX_IDLE;
            cnt        <= '0;
            idx        <= '0;
            hold_q     <= '0;
            shift_q    <= '0;
            buf_empty  <= 1'b1;
            released   <= 1'b0;
            load_pulse <= 1'b0;
        end else begin
            load_pulse <= go;
            if (wr) begin
                hold_q    <= wdata;
                buf_empty <= 1'b0;
            end else if (go) begin
                buf_empty <= 1'b1;
            end
            if (tick) cnt <= cnt + 1'b1;
            if (col_hit) released <= 1'b1;
            case (st)
                TX_IDLE, TX_WAIT: begin
                    if (go) begin
                        st       <= TX_START;
                        shift_q  <= hold_q;
                        cnt      <= '0;
                        released <= 1'b0;
                    end else if (st == TX_IDLE && !buf_empty && enable && start_sel) begin
                        st <= TX_WAIT;
                    end else if (st == TX_WAIT && (!enable || !start_sel || buf_empty)) begin
                        st <= TX_IDLE;
                    end
                end
                TX_START: begin
                    if (bit_end) begin
                        st  <= TX_DATA;
                        idx <= '0;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        shift_q <= shift_q >> 1;
                        if (idx == IW'(DATA_BITS - 1)) st <= TX_STOP;
                        else                           idx <= idx + 1'b1;
                    end
                end
                TX_STOP: begin
                    if (bit_end) begin
                        st       <= TX_IDLE;
                        released <= 1'b0;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    always_comb begin
        case (st)
            TX_START: drive = 1'b0;
            TX_DATA:  drive = shift_q[0];
            default:  drive = 1'b1;
        endcase
    end

    assign line_out  = released ? 1'b1 : drive;
    assign checking  = (st == TX_START || st == TX_DATA || st == TX_STOP) && !released;
    assign tick_cnt  = cnt;
    assign reg_empty = (st == TX_IDLE) || (st == TX_WAIT);

endmodule

// File: rtl/sbu_collide.sv
module sbu_collide import sbu_pkg::*; (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          enable,
    input  logic          late,
    input  logic          checking,
    input  logic [CW-1:0] tick_cnt,
    input  logic          driven,
    input  logic          sensed,
    input  logic          clear,
    output logic          hit,
    output logic          flag,
    output logic          irq
);
    assign hit = enable && checking && tick &&
                 (tick_cnt == cmp_point(late)) && (driven != sensed);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            irq <= hit;
            if (hit)        flag <= 1'b1;
            else if (clear) flag <= 1'b0;
        end
    end

endmodule

// File: rtl/sbu_rx.sv
module sbu_rx import sbu_pkg::*; #(
    parameter int DATA_BITS = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 enable,
    input  logic                 line_in,
    input  logic                 line_fall,
    input  logic                 rd,
    output logic [DATA_BITS-1:0] data,
    output logic                 done,
    output rx_err_t              err,
    output logic                 irq
);
    localparam int IW = $clog2(DATA_BITS + 1);

    rx_state_e            st;
    logic [CW-1:0]        cnt;
    logic [IW-1:0]        idx;
    logic [DATA_BITS-1:0] shift_q;
    logic                 samp;

    assign samp = tick && (cnt == RX_MID);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RX_IDLE;
            cnt     <= '0;
            idx     <= '0;
            shift_q <= '0;
            data    <= '0;
            done    <= 1'b0;
            err     <= '0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (rd) done <= 1'b0;
            if (tick) cnt <= cnt + 1'b1;
            if (!enable) begin
                st <= RX_IDLE;
            end else begin
                case (st)
                    RX_IDLE: begin
                        if (line_fall) begin
                            st  <= RX_START;
                            cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (samp) begin
                            if (line_in) st <= RX_IDLE;
                            else begin
                                st  <= RX_DATA;
                                idx <= '0;
                            end
                        end
                    end
                    RX_DATA: begin
                        if (samp) begin
                            shift_q <= {line_in, shift_q[DATA_BITS-1:1]};
                            if (idx == IW'(DATA_BITS - 1)) st <= RX_STOP;
                            else                           idx <= idx + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (samp) begin
                            st          <= RX_IDLE;
                            data        <= shift_q;
                            done        <= 1'b1;
                            irq         <= 1'b1;
                            err.overrun <= done && !rd;
                            err.framing <= !line_in;
                        end
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/shared_bus_uart.sv
module shared_bus_uart import sbu_pkg::*; #(
    parameter int DATA_BITS   = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 baud_tick,
    input  logic                 txe_wr,
    input  logic                 txe_val,
    input  logic                 rx_en,
    input  logic                 inv_pol,
    input  logic                 col_det_en,
    input  logic                 samp_late,
    input  logic                 auto_clr,
    input  logic                 start_sel,
    input  logic                 tx_wr,
    input  logic [DATA_BITS-1:0] tx_data,
    input  logic                 rx_rd,
    input  logic                 col_clr,
    input  logic                 rxd,
    output logic                 txd,
    output logic                 tx_enable,
    output logic                 tx_buf_empty,
    output logic                 tx_reg_empty,
    output logic                 irq_tx,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_done,
    output logic                 err_overrun,
    output logic                 err_frame,
    output logic                 err_sum,
    output logic                 irq_rx,
    output logic                 col_flag,
    output logic                 irq_col
);
    logic          line_s;
    logic          line_q;
    logic          line_fall;
    logic          line_drv;
    logic          checking;
    logic [CW-1:0] tick_cnt;
    logic          col_hit;
    rx_err_t       rx_err;

    generate
        if (SYNC_STAGES <= 1) begin : g_sync1
            logic s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= 1'b1;
                else     s_q <= rxd ^ inv_pol;
            end
            assign line_s = s_q;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] s_q;
            always_ff @(posedge clk) begin
                if (rst) s_q <= '1;
                else     s_q <= {s_q[SYNC_STAGES-2:0], rxd ^ inv_pol};
            end
            assign line_s = s_q[SYNC_STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b1;
        else     line_q <= line_s;
    end
    assign line_fall = line_q && !line_s;

    always_ff @(posedge clk) begin
        if (rst)                      tx_enable <= 1'b0;
        else if (col_hit && auto_clr) tx_enable <= 1'b0;
        else if (txe_wr)              tx_enable <= txe_val;
    end

    sbu_tx #(.DATA_BITS(DATA_BITS)) u_tx (
        .clk        (clk),
        .rst        (rst),
        .tick       (baud_tick),
        .start_sel  (start_sel),
        .enable     (tx_enable),
        .wr         (tx_wr),
        .wdata      (tx_data),
        .line_fall  (line_fall),
        .col_hit    (col_hit),
        .line_out   (line_drv),
        .checking   (checking),
        .tick_cnt   (tick_cnt),
        .buf_empty  (tx_buf_empty),
        .reg_empty  (tx_reg_empty),
        .load_pulse (irq_tx)
    );

    sbu_collide u_col (
        .clk      (clk),
        .rst      (rst),
        .tick     (baud_tick),
        .enable   (col_det_en),
        .late     (samp_late),
        .checking (checking),
        .tick_cnt (tick_cnt),
        .driven   (line_drv),
        .sensed   (line_s),
        .clear    (col_clr),
        .hit      (col_hit),
        .flag     (col_flag),
        .irq      (irq_col)
    );

    sbu_rx #(.DATA_BITS(DATA_BITS)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .tick      (baud_tick),
        .enable    (rx_en),
        .line_in   (line_s),
        .line_fall (line_fall),
        .rd        (rx_rd),
        .data      (rx_data),
        .done      (rx_done),
        .err       (rx_err),
        .irq       (irq_rx)
    );

    assign txd         = line_drv ^ inv_pol;
    assign err_overrun = rx_err.overrun;
    assign err_frame   = rx_err.framing;
    assign err_sum     = rx_err.overrun | rx_err.framing;

endmodule

// File: rtl/sbu_checker.sv
module sbu_checker (
    input logic clk,
    input logic rst,
    input logic inv_pol,
    input logic col_det_en,
    input logic auto_clr,
    input logic col_clr,
    input logic txd,
    input logic tx_enable,
    input logic tx_reg_empty,
    input logic irq_tx,
    input logic err_overrun,
    input logic irq_rx,
    input logic col_flag,
    input logic irq_col
);
    p_idle_level_r1: assert property (@(posedge clk) disable iff (rst)
        tx_reg_empty |-> (txd == !inv_pol));

    p_load_irq_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_reg_empty) |-> irq_tx);

    p_col_gated_r5: assert property (@(posedge clk) disable iff (rst)
        irq_col |-> $past(col_det_en));

    p_col_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (col_flag && !col_clr) |=> col_flag);

    p_col_raises_flag_r5: assert property (@(posedge clk) disable iff (rst)
        irq_col |-> col_flag);

    p_auto_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (irq_col && $past(auto_clr)) |-> !tx_enable);

    p_overrun_on_done_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(err_overrun) |-> irq_rx);

endmodule

bind shared_bus_uart sbu_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .inv_pol      (inv_pol),
    .col_det_en   (col_det_en),
    .auto_clr     (auto_clr),
    .col_clr      (col_clr),
    .txd          (txd),
    .tx_enable    (tx_enable),
    .tx_reg_empty (tx_reg_empty),
    .irq_tx       (irq_tx),
    .err_overrun  (err_overrun),
    .irq_rx       (irq_rx),
    .col_flag     (col_flag),
    .irq_col      (irq_col)
);

// File: tb/sim_shared_bus_uart.sv
module sim_shared_bus_uart;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick;
    logic       txe_wr = 1'b0, txe_val = 1'b0;
    logic       rx_en = 1'b0, inv_pol = 1'b0, col_det_en = 1'b0;
    logic       samp_late = 1'b0, auto_clr = 1'b0, start_sel = 1'b0;
    logic       tx_wr = 1'b0;
    logic [8:0] tx_data = '0;
    logic       rx_rd = 1'b0, col_clr = 1'b0;
    logic       rxd;
    logic       txd, tx_enable, tx_buf_empty, tx_reg_empty, irq_tx;
    logic [8:0] rx_data;
    logic       rx_done, err_overrun, err_frame, err_sum, irq_rx, col_flag, irq_col;

    logic jam = 1'b0, pull = 1'b0;
    int   tick_div = 1;
    int   tcnt = 0;
    int   n_chk = 0, n_fail = 0;
    int   n_tx = 0, n_rx = 0, n_col = 0;

    always #4 clk = ~clk;

    assign rxd       = pull ? inv_pol : (jam ? ~txd : txd);
    assign baud_tick = (tcnt == 0);

    always @(posedge clk) begin
        tcnt <= (tcnt + 1 >= tick_div) ? 0 : tcnt + 1;
        if (irq_tx)  n_tx  <= n_tx + 1;
        if (irq_rx)  n_rx  <= n_rx + 1;
        if (irq_col) n_col <= n_col + 1;
    end

    shared_bus_uart u0 (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .txe_wr(txe_wr), .txe_val(txe_val),
        .rx_en(rx_en), .inv_pol(inv_pol), .col_det_en(col_det_en), .samp_late(samp_late),
        .auto_clr(auto_clr), .start_sel(start_sel), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .col_clr(col_clr), .rxd(rxd), .txd(txd), .tx_enable(tx_enable),
        .tx_buf_empty(tx_buf_empty), .tx_reg_empty(tx_reg_empty), .irq_tx(irq_tx),
        .rx_data(rx_data), .rx_done(rx_done), .err_overrun(err_overrun),
        .err_frame(err_frame), .err_sum(err_sum), .irq_rx(irq_rx),
        .col_flag(col_flag), .irq_col(irq_col)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_txe(input logic v);
        @(negedge clk); txe_wr = 1'b1; txe_val = v;
        @(negedge clk); txe_wr = 1'b0;
    endtask

    task automatic read_rx();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic clear_col();
        @(negedge clk); col_clr = 1'b1;
        @(negedge clk); col_clr = 1'b0;
    endtask

    task automatic wait_idle();
        int lim = 0;
        clocks(3);
        while (!tx_reg_empty && lim < 6000) begin
            @(negedge clk);
            lim++;
        end
        clocks(3);
    endtask

    task automatic write_word(input logic [8:0] w);
        @(negedge clk); tx_data = w; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    // Bit b of the frame is sampled mid-bit; a jam window of jl clocks
    // starts js clocks into frame bit jk (jk < 0: no jam).
    task automatic send_cap(input logic [8:0] w, input int jk, input int js, input int jl,
                            output logic [10:0] cap);
        logic [10:0] c;
        c = '0;
        write_word(w);
        fork
            begin
                for (int b = 0; b < 11; b++) begin
                    clocks(b == 0 ? 7 : 16);
                    c[b] = txd ^ inv_pol;
                end
            end
            begin
                if (jk >= 0) begin
                    clocks(16 * jk + js);
                    jam = 1'b1;
                    clocks(jl);
                    jam = 1'b0;
                end
            end
        join
        cap = c;
        wait_idle();
    endtask

    function automatic logic [10:0] frame_of(input logic [8:0] w, input int hit_bit);
        logic [10:0] f;
        f = {1'b1, w, 1'b0};
        if (hit_bit >= 0)
            for (int b = 0; b < 11; b++) if (b > hit_bit) f[b] = 1'b1;
        return f;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [10:0] cap;
        logic [8:0]  w;
        int          c0, t0, r0;

        clocks(4);
        rst = 1'b0;
        clocks(2);

        // R12 reset state
        check("R12 txd idle", txd, 1);
        check("R12 buf empty", tx_buf_empty, 1);
        check("R12 reg empty", tx_reg_empty, 1);
        check("R12 tx_enable", tx_enable, 0);
        check("R12 rx_done", rx_done, 0);
        check("R12 col_flag", col_flag, 0);
        check("R12 err_sum", err_sum, 0);

        rx_en = 1'b1;
        col_det_en = 1'b1;
        set_txe(1'b1);

        // R1/R2/R3/R9 loopback sweep, both polarities
        for (int p = 0; p < 2; p++) begin
            inv_pol = p[0];
            clocks(6);
            for (int i = 0; i < 96; i++) begin
                w = (i == 0) ? 9'h000 : (i == 1) ? 9'h1FF : 9'((i * 149 + i * i * 7 + 3) & 511);
                t0 = n_tx;
                r0 = n_rx;
                send_cap(w, -1, 0, 0, cap);
                check(p == 0 ? "R1 frame waveform" : "R2 inverted waveform", cap, frame_of(w, -1));
                check("R9 rx_data", rx_data, w);
                check("R9 rx_done and irq_rx", {rx_done, 1'b0} + (n_rx - r0), 3);
                check("R11 no error on clean frame", err_sum, 0);
                check("R3 irq_tx and buffer empty", {tx_buf_empty, 1'b0} + (n_tx - t0), 3);
                read_rx();
                if (i == 0) check("R9 rx_rd clears done", rx_done, 0);
            end
        end
        check("R5 no collision on clean loopback", col_flag, 0);
        inv_pol = 1'b0;
        clocks(6);

        // R13 reg empty during frame
        write_word(9'h0F3);
        clocks(20);
        check("R13 reg busy mid-frame", tx_reg_empty, 0);
        wait_idle();
        check("R13 reg empty after frame", tx_reg_empty, 1);
        read_rx();

        // R5/R6/R7 mid-point disturbance, mid sampling
        samp_late = 1'b0;
        c0 = n_col;
        send_cap(9'h0AA, 3, 4, 5, cap);
        check("R6 mid jam seen at mid point", col_flag, 1);
        check("R5 one irq_col", n_col - c0, 1);
        check("R7 released to idle after hit", cap, frame_of(9'h0AA, 3));
        check("R8 no auto clear keeps enable", tx_enable, 1);
        read_rx();
        send_cap(9'h055, -1, 0, 0, cap);
        check("R7 flag sticky across frames", col_flag, 1);
        check("R7 next frame normal", cap, frame_of(9'h055, -1));
        clear_col();
        check("R7 col_clr clears flag", col_flag, 0);
        read_rx();

        // R6 late disturbance, mid sampling: ignored
        send_cap(9'h0AA, 3, 12, 5, cap);
        check("R6 late jam ignored at mid point", col_flag, 0);
        check("R6 frame intact", cap, frame_of(9'h0AA, -1));
        read_rx();

        // R6 late disturbance, late sampling
        samp_late = 1'b1;
        c0 = n_col;
        send_cap(9'h000, 5, 12, 5, cap);
        check("R6 late jam seen at end point", col_flag, 1);
        check("R5 irq_col late", n_col - c0, 1);
        check("R7 released after late hit", cap, frame_of(9'h000, 5));
        clear_col();
        read_rx();

        // R6 mid disturbance, late sampling: ignored
        send_cap(9'h133, 2, 4, 5, cap);
        check("R6 mid jam ignored at end point", col_flag, 0);
        check("R6 frame intact late", cap, frame_of(9'h133, -1));
        read_rx();

        // R5 detection disabled
        samp_late = 1'b0;
        col_det_en = 1'b0;
        c0 = n_col;
        send_cap(9'h0AA, 3, 4, 5, cap);
        check("R5 disabled no flag", col_flag, 0);
        check("R5 disabled no irq", n_col - c0, 0);
        check("R5 disabled frame intact", cap, frame_of(9'h0AA, -1));
        read_rx();
        col_det_en = 1'b1;

        // R8 auto clear
        auto_clr = 1'b1;
        send_cap(9'h1C7, 2, 4, 5, cap);
        check("R8 auto clear drops enable", tx_enable, 0);
        write_word(9'h021);
        clocks(60);
        check("R8 word held while disabled", {tx_buf_empty, tx_reg_empty}, 2'b01);
        auto_clr = 1'b0;
        clear_col();
        set_txe(1'b1);
        wait_idle();
        check("R3 word sent after re-enable", tx_buf_empty, 1);
        check("R9 re-enabled word received", rx_data, 9'h021);
        read_rx();

        // R10 overrun
        write_word(9'h111); wait_idle();
        write_word(9'h0EE); wait_idle();
        check("R10 overrun set", err_overrun, 1);
        check("R11 summary follows overrun", err_sum, 1);
        check("R10 latest data kept", rx_data, 9'h0EE);
        read_rx();
        write_word(9'h07C); wait_idle();
        check("R10 overrun cleared after read", err_overrun, 0);
        check("R9 data after read", rx_data, 9'h07C);
        read_rx();

        // R11 framing error
        col_det_en = 1'b0;
        send_cap(9'h0C3, 10, 4, 8, cap);
        check("R11 framing error", err_frame, 1);
        check("R11 summary on framing", err_sum, 1);
        read_rx();
        col_det_en = 1'b1;

        // R4 start on falling edge
        start_sel = 1'b1;
        write_word(9'h05A);
        clocks(40);
        check("R4 waits for edge", {tx_reg_empty, tx_buf_empty, txd}, 3'b101);
        @(negedge clk); pull = 1'b1;
        clocks(2);
        pull = 1'b0;
        clocks(8);
        check("R4 starts after edge", tx_reg_empty, 0);
        wait_idle();
        check("R4 buffer consumed", tx_buf_empty, 1);
        start_sel = 1'b0;
        clear_col();
        read_rx();

        // R1 slower tick spacing
        tick_div = 4;
        clocks(4);
        write_word(9'h1A5);
        wait_idle();
        check("R1 frame with spaced ticks", rx_data, 9'h1A5);
        check("R1 no error with spaced ticks", err_sum, 0);
        tick_div = 1;

        summary();
        $finish;
    end

endmodule